// File: doc/BRIEF.md
# Random-Interval ADC Entropy Sequencer

This block turns a slowly moving analog voltage into a stream of 16-bit true random words. It drives one charge/discharge pin that feeds an external RC or sensor network. It starts conversions on an on-chip ADC at intervals that depend on the data. Each 12-bit sample is folded into a 4-bit nibble. A small 256 x 16 word memory holds earlier random words. Those words are read back, indexed by the current sample, to choose the waiting times, the switching thresholds and the rotation amounts. This closes a feedback loop in which every sample disturbs the timing of the next.

Software requests a number of words and sets two delay masks. The sequencer then runs by itself. It delivers each finished word on a valid/ready output and also writes that word back into the memory. The memory can be filled in advance through a preload write port. The analog side and the ADC are outside the block.

Top module: `rand_sample_seq`

## Requirements
- R12: After reset, charge_o, busy_o, adc_start_o and rnd_valid_o are all 0, the write pointer is 0, and the stored previous sample is 0.
- R1: A start request accepted while idle drives charge_o to 1 and busy_o to 1 on the next cycle, and clears the count of delivered words.
- R2: Before the first conversion of a run, the block waits an extra (mem[wr_ptr-1] AND mask_init_i) cycles. At reset, wr_ptr-1 is address 255.
- R3: At the start of each word, the block reads w = mem[~prev[7:0]], where prev is the previous sample. It forms hi = 0x800 + w[15:6] and lo = 0x800 - w[9:0]. If prev > hi, charge_o goes to 0. If prev < lo, charge_o goes to 1. Otherwise charge_o keeps its value.
- R4: Before every conversion, the block waits an extra (mem[prev[7:0]] AND mask_gap_i) cycles. prev is the sample converted just before.
- R5: Each conversion begins with adc_start_o high for exactly one cycle. The sample is taken from adc_data_i in the cycle in which adc_done_i is high.
- R6: For a sample s, the rotation amount is the 3-bit value {mem[s+1][0], mem[s+2][0], mem[s+3][0]}, with addresses taken modulo 256 and the first bit as the MSB. The nibble is bits [3:0] of s rotated right by that amount.
- R7: Four nibbles make one word. The first nibble goes into bits [3:0], and each later nibble goes into the next higher 4 bits.
- R8: Each completed word is written to mem[wr_ptr], and wr_ptr then increments modulo 256. Later reads of that address return the word.
- R9: rnd_valid_o stays high and rnd_word_o stays stable until rnd_ready_i is seen high. No conversion starts during that time.
- R10: Once word_count_i words have been accepted, busy_o drops to 0. No further conversions or words occur until the next start.
- R11: When pre_we_i is high, pre_data_i is written to mem[pre_addr_i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled while idle |
| word_count_i | input | 16 | Number of words to deliver (at least 1) |
| mask_init_i | input | 16 | Mask for the initial delay |
| mask_gap_i | input | 16 | Mask for the delay before each conversion |
| charge_o | output | 1 | 1 = charge the network, 0 = discharge |
| busy_o | output | 1 | A run is in progress |
| adc_start_o | output | 1 | One-cycle conversion start |
| adc_done_i | input | 1 | Conversion result valid |
| adc_data_i | input | 12 | Conversion result |
| rnd_valid_o | output | 1 | rnd_word_o holds a new word |
| rnd_ready_i | input | 1 | The consumer accepts the word |
| rnd_word_o | output | 16 | Random word |
| pre_we_i | input | 1 | Preload write enable |
| pre_addr_i | input | 8 | Preload address |
| pre_data_i | input | 16 | Preload data |

## Verification
The assertions assume an ADC that answers each start pulse with exactly one done pulse and never raises done otherwise. They also assume that the count and both masks stay steady while busy_o is high, that preload writes happen only while idle, and that the requested count is at least 1. The bench's ADC model replies once, two cycles after each start pulse. The bench changes the count and the masks only between runs, and it preloads the memory before the first start. It also checks the delays and the pin direction against its own mirror of the memory contents.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int ROT_W = 3;

  typedef enum logic [4:0] {
    ST_IDLE, ST_SEED_RD, ST_SEED_WT, ST_SEED_DLY,
    ST_THR_RD, ST_THR_WT, ST_GAP_RD, ST_GAP_WT, ST_GAP_DLY,
    ST_CONV, ST_WAIT, ST_ROT1, ST_ROT2, ST_ROT3, ST_ROT4,
    ST_WR, ST_OUT
  } rs_state_e;
endpackage

// File: rtl/rs_word_ram.sv
module rs_word_ram #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/rs_delay_ctr.sv
module rs_delay_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         dec_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)     cnt_d = val_i;
    else if (dec_i) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (load_i || dec_i)  cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/rs_thresh.sv
module rs_thresh #(
  parameter int SAMPLE_W = 12,
  parameter int WORD_W   = 16
) (
  input  logic [WORD_W-1:0]   rnd_i,
  input  logic [SAMPLE_W-1:0] level_i,
  input  logic                chg_i,
  output logic                chg_o
);
  localparam int FW = SAMPLE_W - 2;
  localparam logic [SAMPLE_W-1:0] MID = 1 << (SAMPLE_W - 1);
  logic [SAMPLE_W-1:0] hi, lo;

  always_comb begin
    hi = MID + {2'b00, rnd_i[WORD_W-1 -: FW]};
    lo = MID - {2'b00, rnd_i[FW-1:0]};
    if (level_i > hi)      chg_o = 1'b0;
    else if (level_i < lo) chg_o = 1'b1;
    else                   chg_o = chg_i;
  end
endmodule

// File: rtl/rs_rot_extract.sv
module rs_rot_extract #(
  parameter int SAMPLE_W = 12,
  parameter int ROT_W    = 3,
  parameter int NIB_W    = 4
) (
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic [ROT_W-1:0]    amt_i,
  output logic [NIB_W-1:0]    nib_o
);
  always_comb begin
    for (int i = 0; i < NIB_W; i++)
      nib_o[i] = sample_i[(i + int'(amt_i)) % SAMPLE_W];
  end
endmodule

// File: rtl/rand_sample_seq.sv
module rand_sample_seq
  import rs_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int WORD_W   = 16,
  parameter int ADDR_W   = 8,
  parameter int NIB_W    = 4,
  parameter int CNT_W    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [CNT_W-1:0]    word_count_i,
  input  logic [WORD_W-1:0]   mask_init_i,
  input  logic [WORD_W-1:0]   mask_gap_i,
  output logic                charge_o,
  output logic                busy_o,
  output logic                adc_start_o,
  input  logic                adc_done_i,
  input  logic [SAMPLE_W-1:0] adc_data_i,
  output logic                rnd_valid_o,
  input  logic                rnd_ready_i,
  output logic [WORD_W-1:0]   rnd_word_o,
  input  logic                pre_we_i,
  input  logic [ADDR_W-1:0]   pre_addr_i,
  input  logic [WORD_W-1:0]   pre_data_i
);
  localparam int NIBS  = WORD_W / NIB_W;
  localparam int IDX_W = $clog2(NIBS);
  localparam logic [ADDR_W-1:0] A1 = 1;
  localparam logic [ADDR_W-1:0] A2 = 2;
  localparam logic [ADDR_W-1:0] A3 = 3;
  localparam logic [IDX_W-1:0]  LAST_NIB = IDX_W'(NIBS - 1);

  rs_state_e           st_q, st_d;
  logic                chg_q, chg_d;
  logic [SAMPLE_W-1:0] prev_q, prev_d, samp_q, samp_d;
  logic [1:0]          roth_q, roth_d;
  logic [WORD_W-1:0]   acc_q, acc_d;
  logic [IDX_W-1:0]    nib_q, nib_d;
  logic [ADDR_W-1:0]   wp_q, wp_d;
  logic [CNT_W-1:0]    done_q, done_d;
  logic                vld_q, vld_d;

  logic [ADDR_W-1:0]   raddr, waddr;
  logic [WORD_W-1:0]   rdata, wdata;
  logic                int_we, ram_we;
  logic                dly_load, dly_dec, dly_zero;
  logic [WORD_W-1:0]   dly_val;
  logic                thr_chg;
  logic [NIB_W-1:0]    nib;

  assign ram_we = int_we | pre_we_i;
  assign waddr  = int_we ? wp_q  : pre_addr_i;
  assign wdata  = int_we ? acc_q : pre_data_i;

  rs_word_ram #(.ADDR_W(ADDR_W), .DATA_W(WORD_W)) u_ram (
    .clk(clk), .we(ram_we), .waddr(waddr), .wdata(wdata),
    .raddr(raddr), .rdata(rdata));

  rs_delay_ctr #(.W(WORD_W)) u_dly (
    .clk(clk), .rst_n(rst_n), .load_i(dly_load), .val_i(dly_val),
    .dec_i(dly_dec), .zero_o(dly_zero));

  rs_thresh #(.SAMPLE_W(SAMPLE_W), .WORD_W(WORD_W)) u_thr (
    .rnd_i(rdata), .level_i(prev_q), .chg_i(chg_q), .chg_o(thr_chg));

  rs_rot_extract #(.SAMPLE_W(SAMPLE_W), .ROT_W(ROT_W), .NIB_W(NIB_W)) u_rot (
    .sample_i(samp_q), .amt_i({roth_q, rdata[0]}), .nib_o(nib));

  // read address selection per state
  always_comb begin
    unique case (st_q)
      ST_SEED_RD: raddr = wp_q - A1;
      ST_THR_RD:  raddr = ~prev_q[ADDR_W-1:0];
      ST_GAP_RD:  raddr = prev_q[ADDR_W-1:0];
      ST_ROT1:    raddr = samp_q[ADDR_W-1:0] + A1;
      ST_ROT2:    raddr = samp_q[ADDR_W-1:0] + A2;
      ST_ROT3:    raddr = samp_q[ADDR_W-1:0] + A3;
      default:    raddr = prev_q[ADDR_W-1:0];
    endcase
  end

  // next-state logic
  always_comb begin
    st_d = st_q; chg_d = chg_q; prev_d = prev_q; samp_d = samp_q;
    roth_d = roth_q; acc_d = acc_q; nib_d = nib_q; wp_d = wp_q;
    done_d = done_q; vld_d = vld_q;
    int_we = 1'b0; dly_load = 1'b0; dly_dec = 1'b0; dly_val = '0;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        chg_d = 1'b1; done_d = '0; st_d = ST_SEED_RD;
      end
      ST_SEED_RD: st_d = ST_SEED_WT;
      ST_SEED_WT: begin
        dly_load = 1'b1; dly_val = rdata & mask_init_i; st_d = ST_SEED_DLY;
      end
      ST_SEED_DLY: if (dly_zero) st_d = ST_THR_RD; else dly_dec = 1'b1;
      ST_THR_RD: begin acc_d = '0; nib_d = '0; st_d = ST_THR_WT; end
      ST_THR_WT: begin chg_d = thr_chg; st_d = ST_GAP_RD; end
      ST_GAP_RD: st_d = ST_GAP_WT;
      ST_GAP_WT: begin
        dly_load = 1'b1; dly_val = rdata & mask_gap_i; st_d = ST_GAP_DLY;
      end
      ST_GAP_DLY: if (dly_zero) st_d = ST_CONV; else dly_dec = 1'b1;
      ST_CONV: st_d = ST_WAIT;
      ST_WAIT: if (adc_done_i) begin samp_d = adc_data_i; st_d = ST_ROT1; end
      ST_ROT1: st_d = ST_ROT2;
      ST_ROT2: begin roth_d[1] = rdata[0]; st_d = ST_ROT3; end
      ST_ROT3: begin roth_d[0] = rdata[0]; st_d = ST_ROT4; end
      ST_ROT4: begin
        acc_d[nib_q*NIB_W +: NIB_W] = nib;
        prev_d = samp_q;
        nib_d  = nib_q + 1'b1;
        st_d   = (nib_q == LAST_NIB) ? ST_WR : ST_GAP_RD;
      end
      ST_WR: begin int_we = 1'b1; wp_d = wp_q + A1; vld_d = 1'b1; st_d = ST_OUT; end
      ST_OUT: if (rnd_ready_i) begin
        vld_d  = 1'b0;
        done_d = done_q + 1'b1;
        st_d   = (done_d >= word_count_i) ? ST_IDLE : ST_THR_RD;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; chg_q <= 1'b0; prev_q <= '0; samp_q <= '0;
      roth_q <= '0; acc_q <= '0; nib_q <= '0; wp_q <= '0;
      done_q <= '0; vld_q <= 1'b0;
    end else begin
      st_q <= st_d; chg_q <= chg_d; prev_q <= prev_d; samp_q <= samp_d;
      roth_q <= roth_d; acc_q <= acc_d; nib_q <= nib_d; wp_q <= wp_d;
      done_q <= done_d; vld_q <= vld_d;
    end
  end

  assign charge_o    = chg_q;
  assign busy_o      = (st_q != ST_IDLE);
  assign adc_start_o = (st_q == ST_CONV);
  assign rnd_valid_o = vld_q;
  assign rnd_word_o  = acc_q;
endmodule

// File: rtl/rs_seq_chk.sv
module rs_seq_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              charge_o,
  input logic              busy_o,
  input logic              adc_start_o,
  input logic              rnd_valid_o,
  input logic              rnd_ready_i,
  input logic [WORD_W-1:0] rnd_word_o
);
  a_r5_start_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start_o |=> !adc_start_o);

  a_r9_valid_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rnd_valid_o && !rnd_ready_i) |=> (rnd_valid_o && $stable(rnd_word_o)));

  a_r9_no_conv_while_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rnd_valid_o |-> !adc_start_o);

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!rnd_valid_o && !adc_start_o));

  a_r1_start_charges: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> charge_o);
endmodule

bind rand_sample_seq rs_seq_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .charge_o(charge_o), .busy_o(busy_o),
  .adc_start_o(adc_start_o), .rnd_valid_o(rnd_valid_o),
  .rnd_ready_i(rnd_ready_i), .rnd_word_o(rnd_word_o));

// File: tb/test_rand_sample_seq.sv
module test_rand_sample_seq;
  logic        clk, rst_n, start_i, charge_o, busy_o, adc_start_o, adc_done_i;
  logic [15:0] word_count_i, mask_init_i, mask_gap_i, rnd_word_o, pre_data_i;
  logic [11:0] adc_data_i;
  logic        rnd_valid_o, rnd_ready_i, pre_we_i;
  logic [7:0]  pre_addr_i;

  int checks = 0, errors = 0;
  logic [15:0] mdl [256];
  logic [11:0] adc_seq [64];
  int aidx = 0, wp = 0, sidx = 0, base_lat = 0;
  logic [11:0] prv = '0;
  logic mchg = 1'b0;

  rand_sample_seq i_rand_sample_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .word_count_i(word_count_i),
    .mask_init_i(mask_init_i), .mask_gap_i(mask_gap_i), .charge_o(charge_o),
    .busy_o(busy_o), .adc_start_o(adc_start_o), .adc_done_i(adc_done_i),
    .adc_data_i(adc_data_i), .rnd_valid_o(rnd_valid_o), .rnd_ready_i(rnd_ready_i),
    .rnd_word_o(rnd_word_o), .pre_we_i(pre_we_i), .pre_addr_i(pre_addr_i),
    .pre_data_i(pre_data_i));

  initial begin clk = 1'b0; forever #10 clk = ~clk; end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // ADC model: answers every start pulse two cycles later
  initial begin
    adc_done_i = 1'b0; adc_data_i = '0;
    forever begin
      @(negedge clk);
      if (adc_start_o) begin
        @(negedge clk); @(negedge clk);
        adc_done_i = 1'b1; adc_data_i = adc_seq[aidx]; aidx++;
        @(negedge clk);
        adc_done_i = 1'b0;
      end
    end
  end

  function automatic logic [15:0] exp_word(int b);
    logic [15:0] w;
    logic [11:0] s;
    int r;
    w = '0;
    for (int n = 0; n < 4; n++) begin
      s = adc_seq[b + n];
      r = {mdl[(int'(s) + 1) % 256][0], mdl[(int'(s) + 2) % 256][0],
           mdl[(int'(s) + 3) % 256][0]};
      for (int k = 0; k < 4; k++) w[n*4 + k] = s[(k + r) % 12];
    end
    return w;
  endfunction

  task automatic apply_thresh();
    logic [15:0] w;
    int hi, lo;
    w  = mdl[(~int'(prv)) & 255];
    hi = 'h800 + int'(w[15:6]);
    lo = 'h800 - int'(w[9:0]);
    if (int'(prv) > hi) mchg = 1'b0;
    else if (int'(prv) < lo) mchg = 1'b1;
  endtask

  task automatic run_words(input int cnt, input int m1, input int m2,
                           input bit stall, input bit first);
    int c1, c2, lat;
    logic [15:0] ew, held;
    c1 = int'(mdl[(wp + 255) % 256]) & m1;
    c2 = int'(mdl[int'(prv[7:0])]) & m2;
    word_count_i = 16'(cnt); mask_init_i = 16'(m1); mask_gap_i = 16'(m2);
    mchg = 1'b1;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    check(busy_o === 1'b1 && charge_o === 1'b1, "R1 start", {busy_o, charge_o}, 3);
    lat = 0;
    while (!adc_start_o) begin @(negedge clk); lat++; end
    if (first) base_lat = lat;
    else check(lat == base_lat + c1 + c2, "R2 R4 R8 delay", lat, base_lat + c1 + c2);
    for (int w = 0; w < cnt; w++) begin
      if (w > 0) while (!adc_start_o) @(negedge clk);
      apply_thresh();
      check(charge_o === mchg, "R3 pin", charge_o, mchg);
      while (!rnd_valid_o) @(negedge clk);
      ew = exp_word(sidx);
      if (stall && w == 0) begin
        held = rnd_word_o;
        repeat (4) @(negedge clk);
        check(rnd_valid_o === 1'b1 && rnd_word_o === held && !adc_start_o,
              "R9 hold", rnd_word_o, held);
      end
      check(rnd_word_o === ew, "R6 R7 R11 word", rnd_word_o, ew);
      rnd_ready_i = 1'b1; @(negedge clk); rnd_ready_i = 1'b0;
      mdl[wp] = ew; wp = (wp + 1) % 256;
      prv = adc_seq[sidx + 3]; sidx += 4;
    end
    @(negedge clk);
    check(busy_o === 1'b0, "R10 idle", busy_o, 0);
    begin
      bit quiet = 1'b1;
      repeat (40) begin @(negedge clk); if (adc_start_o || rnd_valid_o) quiet = 1'b0; end
      check(quiet, "R10 no further conversion", !quiet, 0);
    end
  endtask

  task automatic t_reset();
    check({charge_o, busy_o, adc_start_o, rnd_valid_o} === 4'b0000, "R12 reset",
          {charge_o, busy_o, adc_start_o, rnd_valid_o}, 0);
  endtask

  task automatic t_preload();
    for (int i = 0; i < 256; i++) begin
      mdl[i] = 16'((i * 40503 + 4660) ^ (i << 5));
      @(negedge clk); pre_we_i = 1'b1; pre_addr_i = 8'(i); pre_data_i = mdl[i];
    end
    @(negedge clk); pre_we_i = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; rnd_ready_i = 1'b0; pre_we_i = 1'b0;
    pre_addr_i = '0; pre_data_i = '0; word_count_i = 16'd1;
    mask_init_i = '0; mask_gap_i = '0;
    for (int k = 0; k < 64; k++) adc_seq[k] = 12'((k * 'h3A7 + 'h155) & 'hFFF);
    adc_seq[15] = 12'hFFF; adc_seq[19] = 12'h000; adc_seq[23] = 12'h800;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_preload();
    run_words(1, 0, 0, 1'b0, 1'b1);      // baseline
    run_words(1, 'h3F, 0, 1'b0, 1'b0);   // initial delay from the word just stored
    run_words(1, 0, 'h0F, 1'b0, 1'b0);   // gap delay indexed by previous sample
    run_words(3, 'h0F, 'h07, 1'b1, 1'b0); // thresholds swing the pin, held output
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule